// File: doc/BRIEF.md
# Serial Command Front End for a 16-bit Successive-Approximation Converter

This block is the digital side of a serially controlled 16-bit converter. A host talks to it over a four-wire link: an active-low select, a serial clock, a data input and a data output. It also drives a strobe output. The block samples every link signal on its own system clock and finds the clock edges there. It waits for a command byte, which begins with a start bit. The byte chooses the input range, the conversion clock source, an operating mode and the value of three general-purpose outputs. Those outputs typically steer an external multiplexer or gain stage.

With the serial clock as the conversion clock, the block counts falling edges from the start bit. Each frame is 24 or 32 edges long. The strobe marks the edge just before the result appears, and the 16-bit result is then shifted out. The analog converter itself is not modelled. A parallel two's-complement code input stands in for it. A request pulse hands internal-clock conversions to an outside sequencer, which answers with a done pulse. Each tri-state pin is modelled as a value plus an enable.

Top module: `sar_cmd_port`

## Requirements
- R1: Reset (asynchronous, active low) leaves the block idle and waiting for a start bit. In that state `gpo` is 0, `pdown` is 0 and `sstrb` is 0. With `cs_n` high, both `dout_oe` and `sstrb_oe` are 0.
- R2: While the block waits, zeros sampled on rising serial-clock edges have no effect. The first 1 sampled is the start bit, which is bit 7 of the command byte. The other seven bits follow, MSB first.
- R3: Bit 6 of the command sets `range_uni` (1 = unipolar) and bit 5 sets `clk_int` (1 = internal clock). Bits 4:3 set the mode. Code 00 selects a 24-edge conversion and 11 selects a 32-edge conversion. Code 01 gives a one-cycle `cal_go` pulse. Code 10 sets `pdown`, and `pdown` stays set until the next conversion or calibration command.
- R4: Bits 2:0 of the command load `gpo[2:0]`, with bit 2 going to `gpo[2]`. All three bits change together on the rising edge that carries bit 0. At every other time, power-down included, `gpo` holds its value.
- R5: For an external-clock 24-edge command, `sstrb` is high from falling edge 7 to falling edge 8, counted from the start bit. The result MSB is on `dout` from falling edge 8.
- R6: For an external-clock 32-edge command, `sstrb` is high from falling edge 15 to falling edge 16, and the MSB is on `dout` from falling edge 16.
- R7: `conv_data` is sampled on the falling edge where the MSB first appears. `dout` then moves to the next lower bit on each later falling edge. In bipolar mode the result is `conv_data` unchanged. In unipolar mode it is `conv_data` with its MSB inverted.
- R8: `dout_oe` is 1 exactly while `cs_n` is low. When `clk_int` is 0, `sstrb_oe` behaves the same way. Serial clock edges while `cs_n` is high are ignored, and a frame paused that way resumes unchanged once `cs_n` returns low.
- R9: If `cs_n` rises and falls during a conversion, the block looks for a start bit again. A start bit that then arrives drops the running frame and begins a new command.
- R10: An internal-clock conversion command gives a one-cycle `int_go` pulse. `sstrb` is then driven low with `sstrb_oe` at 1 whatever `cs_n` is. A `conv_done` pulse captures `conv_data`, raises `sstrb` and puts the MSB on `dout`. Each later falling edge with `cs_n` low shifts out the next bit.
- R11: After falling edge 24 or 32 of an external frame, the block waits for a new start bit. No select toggle is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Link select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| conv_data | input | 16 | Two's-complement converter code |
| conv_done | input | 1 | Internal-clock conversion finished (one-cycle pulse) |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for dout |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Drive enable for sstrb |
| gpo | output | 3 | General-purpose port outputs |
| range_uni | output | 1 | Unipolar range selected |
| clk_int | output | 1 | Internal conversion clock selected |
| pdown | output | 1 | Power-down mode |
| cal_go | output | 1 | Calibration request pulse |
| int_go | output | 1 | Internal-clock conversion request pulse |

## Verification
A wrong bit count while the command byte comes in shows up by the next frame. Either `gpo` and `range_uni` take values shifted by one bit, or the strobe lands on the wrong edge of a frame that started early or late. A wrong falling-edge counter moves the strobe and the result window together, so sampling `sstrb` and `dout` after every falling edge finds it within one frame. A stuck select-rearm flag shows up only in the abort and split-transfer cases. In the first the old result keeps shifting out. In the second the frame restarts on a stray 1.

// File: rtl/sar_cmd_port.sv
module sar_cmd_port #(
  parameter int DW       = 16,
  parameter int SHORT_FR = 24,
  parameter int LONG_FR  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  input  logic [DW-1:0] conv_data,
  input  logic          conv_done,
  output logic          dout,
  output logic          dout_oe,
  output logic          sstrb,
  output logic          sstrb_oe,
  output logic [2:0]    gpo,
  output logic          range_uni,
  output logic          clk_int,
  output logic          pdown,
  output logic          cal_go,
  output logic          int_go
);

  localparam int CW    = $clog2(LONG_FR + 1);
  localparam int SW    = $clog2(DW + 1);
  localparam int STB_S = SHORT_FR - DW - 1;
  localparam int STB_L = LONG_FR - DW - 1;
  localparam int MSB_S = SHORT_FR - DW;
  localparam int MSB_L = LONG_FR - DW;

  typedef enum logic [1:0] {S_HUNT, S_RX, S_CONV, S_INTW} st_t;

  st_t           st;
  logic          sclk_q, cs_q;
  logic [5:0]    rx;
  logic [2:0]    rcnt;
  logic [CW-1:0] fcnt;
  logic          long_q, stb, rearm;
  logic [DW-1:0] sh;
  logic [SW-1:0] shn;

  logic          rise_e, fall_e, cs_fall, start_ok;
  logic [CW-1:0] fnext;
  logic [DW-1:0] res_w;
  logic [1:0]    mode_f;

  assign rise_e   = ~cs_n & sclk & ~sclk_q;
  assign fall_e   = ~cs_n & ~sclk & sclk_q;
  assign cs_fall  = ~cs_n & cs_q;
  assign fnext    = fcnt + 1'b1;
  assign mode_f   = rx[3:2];
  assign res_w    = range_uni ? {~conv_data[DW-1], conv_data[DW-2:0]} : conv_data;
  assign start_ok = rise_e & din &
                    ((st == S_HUNT) | (rearm & ((st == S_CONV) | (st == S_INTW))));

  assign dout     = sh[DW-1];
  assign dout_oe  = ~cs_n;
  assign sstrb    = clk_int ? (st != S_INTW) : stb;
  assign sstrb_oe = clk_int | ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      st        <= S_HUNT;
      rx        <= '0;
      rcnt      <= '0;
      fcnt      <= '0;
      long_q    <= 1'b0;
      stb       <= 1'b0;
      rearm     <= 1'b0;
      sh        <= '0;
      shn       <= '0;
      gpo       <= '0;
      range_uni <= 1'b0;
      clk_int   <= 1'b0;
      pdown     <= 1'b0;
      cal_go    <= 1'b0;
      int_go    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      cal_go <= 1'b0;
      int_go <= 1'b0;

      if (cs_fall && (st == S_CONV || st == S_INTW))
        rearm <= 1'b1;

      if (fall_e && shn != '0) begin
        sh  <= {sh[DW-2:0], 1'b0};
        shn <= shn - 1'b1;
      end

      if (start_ok) begin
        st    <= S_RX;
        rcnt  <= '0;
        fcnt  <= '0;
        rearm <= 1'b0;
        stb   <= 1'b0;
        sh    <= '0;
        shn   <= '0;
      end else begin
        unique case (st)
          S_RX: begin
            if (fall_e) begin
              fcnt <= fnext;
              if (fnext == CW'(STB_S) && !rx[4] && mode_f == 2'b00)
                stb <= 1'b1;
            end
            if (rise_e) begin
              rx   <= {rx[4:0], din};
              rcnt <= rcnt + 1'b1;
              if (rcnt == 3'd6) begin
                gpo       <= {rx[1:0], din};
                range_uni <= rx[5];
                clk_int   <= rx[4];
                unique case (mode_f)
                  2'b01: begin
                    cal_go <= 1'b1;
                    pdown  <= 1'b0;
                    st     <= S_HUNT;
                  end
                  2'b10: begin
                    pdown <= 1'b1;
                    st    <= S_HUNT;
                  end
                  default: begin
                    pdown  <= 1'b0;
                    long_q <= mode_f[0];
                    if (rx[4]) begin
                      int_go <= 1'b1;
                      st     <= S_INTW;
                    end else begin
                      st <= S_CONV;
                    end
                  end
                endcase
              end
            end
          end
          S_CONV: begin
            if (fall_e) begin
              fcnt <= fnext;
              stb  <= long_q && fnext == CW'(STB_L);
              if (fnext == (long_q ? CW'(MSB_L) : CW'(MSB_S))) begin
                sh  <= res_w;
                shn <= SW'(DW);
              end
              if (fnext == (long_q ? CW'(LONG_FR) : CW'(SHORT_FR))) begin
                st    <= S_HUNT;
                rearm <= 1'b0;
              end
            end
          end
          S_INTW: begin
            if (conv_done) begin
              sh    <= res_w;
              shn   <= SW'(DW);
              st    <= S_HUNT;
              rearm <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  gpo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpo) |-> $past(rise_e));

  // R5
  stb_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |-> $past(fall_e));

  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shn != $past(shn)) |-> (32'(shn) == 32'($past(shn)) - 1 || shn == SW'(DW) || shn == '0));

  // R10
  ext_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> !clk_int);

endmodule

// File: tb/sar_cmd_port_tb.sv
module sar_cmd_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [15:0] conv_data = '0;
  logic conv_done = 1'b0;
  logic dout, dout_oe, sstrb, sstrb_oe, range_uni, clk_int, pdown, cal_go, int_go;
  logic [2:0] gpo;

  int total = 0;
  int bad = 0;
  int cal_cnt = 0;
  int int_cnt = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  sar_cmd_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_data(conv_data), .conv_done(conv_done),
    .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb), .sstrb_oe(sstrb_oe),
    .gpo(gpo), .range_uni(range_uni), .clk_int(clk_int), .pdown(pdown),
    .cal_go(cal_go), .int_go(int_go)
  );

  always @(posedge clk) begin
    if (cal_go) cal_cnt <= cal_cnt + 1;
    if (int_go) int_cnt <= int_cnt + 1;
  end

  // cmd, data, expected word, strobe edge, leading zeros
  localparam logic [49:0] TBL [0:4] = '{
    {8'hC5, 16'h8000, 16'h0000, 6'd7,  4'd0},
    {8'h83, 16'h1234, 16'h1234, 6'd7,  4'd3},
    {8'hDE, 16'h7FFF, 16'hFFFF, 6'd15, 4'd1},
    {8'h99, 16'hA5C3, 16'hA5C3, 6'd15, 4'd5},
    {8'hC7, 16'h0001, 16'h8001, 6'd7,  4'd0}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    din = b;
    sclk = 1'b1;
    tick(3);
    sclk = 1'b0;
    tick(3);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) sbit(c[i]);
  endtask

  task automatic run_frame(input logic [7:0] cmd, input logic [15:0] data, input int pre,
                           input int stbk, input int split,
                           output logic [63:0] got_stb, output logic [15:0] got_word);
    int nclk;
    nclk = stbk + 17;
    conv_data = data;
    got_stb = '0;
    got_word = '0;
    for (int i = 0; i < pre + nclk; i++) begin
      int k;
      logic b;
      k = i - pre + 1;
      b = (k >= 1 && k <= 8) ? cmd[8 - k] : 1'b0;
      if (split != 0 && k == split) begin
        cs_n = 1'b1;
        tick(3);
        chk("R8 dout_oe with cs high", dout_oe, 0);
        chk("R8 sstrb_oe with cs high", sstrb_oe, 0);
        for (int j = 0; j < 3; j++) sbit(1'b1);
        cs_n = 1'b0;
        tick(3);
      end
      sbit(b);
      if (k >= 1) got_stb[k] = sstrb;
      if (k >= stbk + 1 && k <= stbk + 16) got_word[15 - (k - stbk - 1)] = dout;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired got=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] gs;
    logic [15:0] gw;
    int c0;

    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 gpo", gpo, 0);
    chk("R1 pdown", pdown, 0);
    chk("R1 sstrb", sstrb, 0);
    chk("R1 dout_oe", dout_oe, 0);
    chk("R1 sstrb_oe", sstrb_oe, 0);

    cs_n = 1'b0;
    tick(3);
    chk("R8 dout_oe with cs low", dout_oe, 1);

    // R2 leading zeros, R5/R6 strobe, R7 result, R11 back to back frames
    for (int e = 0; e < 5; e++) begin
      logic [49:0] v;
      logic [63:0] es;
      v = TBL[e];
      run_frame(v[49:42], v[41:26], int'(v[3:0]), int'(v[9:4]), 0, gs, gw);
      es = '0;
      es[v[9:4]] = 1'b1;
      chk($sformatf("R5 R6 strobe edge entry %0d", e), gs, es);
      chk($sformatf("R7 result word entry %0d", e), gw, v[25:10]);
      chk($sformatf("R4 gpo entry %0d", e), gpo, v[44:42]);
      chk($sformatf("R3 range entry %0d", e), range_uni, v[48]);
    end

    // R3 power-down, R4 gpo held
    send_cmd(8'h92);
    chk("R3 pdown set", pdown, 1);
    chk("R4 gpo from power-down command", gpo, 3'd2);
    for (int j = 0; j < 10; j++) sbit(1'b0);
    chk("R4 gpo held in power-down", gpo, 3'd2);
    chk("R2 zeros leave pdown", pdown, 1);

    // R3 calibration
    c0 = cal_cnt;
    send_cmd(8'h88);
    chk("R3 cal_go pulse count", cal_cnt - c0, 1);
    chk("R3 pdown cleared by calibration", pdown, 0);
    chk("R4 gpo from calibration command", gpo, 3'd0);

    // R8 split transfer
    run_frame(8'h9D, 16'h3C5A, 2, 15, 11, gs, gw);
    chk("R8 split frame strobe", gs, 64'h1 << 15);
    chk("R8 split frame result", gw, 16'h3C5A);

    // R9 abort
    conv_data = 16'h1111;
    send_cmd(8'h81);
    for (int j = 0; j < 4; j++) sbit(1'b0);
    cs_n = 1'b1;
    tick(3);
    cs_n = 1'b0;
    tick(3);
    run_frame(8'h86, 16'h4242, 2, 7, 0, gs, gw);
    chk("R9 abort new strobe", gs, 64'h1 << 7);
    chk("R9 abort new result", gw, 16'h4242);
    chk("R9 abort new gpo", gpo, 3'd6);

    // R10 internal clock
    c0 = int_cnt;
    send_cmd(8'hE4);
    chk("R10 int_go pulse count", int_cnt - c0, 1);
    chk("R10 strobe low while busy", sstrb, 0);
    cs_n = 1'b1;
    tick(3);
    chk("R10 sstrb_oe with cs high", sstrb_oe, 1);
    chk("R8 dout_oe cs high internal", dout_oe, 0);
    cs_n = 1'b0;
    tick(3);
    conv_data = 16'h0F0F;
    conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
    tick(2);
    chk("R10 strobe high when done", sstrb, 1);
    gw[15] = dout;
    for (int j = 14; j >= 0; j--) begin
      sbit(1'b0);
      gw[j] = dout;
    end
    chk("R10 internal result", gw, 16'h8F0F);
    chk("R4 gpo from internal command", gpo, 3'd4);

    // R1 reset in operation
    rst_n = 1'b0;
    tick(2);
    chk("R1 gpo after reset", gpo, 0);
    chk("R1 sstrb after reset", sstrb, 0);
    rst_n = 1'b1;
    tick(2);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule